// File: doc/BRIEF.md
# UART Receive Character Buffer with Error Status

This block buffers received characters on the receive side of a UART and hands them to a CPU over a simple register bus. A character deserializer offers each finished character with a one-cycle valid strobe, eight data bits and three error flags: framing, parity and break. The character and its flags go into a 16-entry first-in first-out store. A bus read of the data offset (0x000) removes the oldest entry and returns its character.

A status word at offset 0x004 shows the error flags that belonged to the entry removed by the most recent data read. It also carries an overrun flag. That flag is raised in the cycle after a character arrives while the store is full, without waiting for any data read. A write of any value to offset 0x004 clears every flag. The bus carries one access per cycle, given by `bus_en` with `bus_we` choosing write or read. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe.

Two small state machines control the block. The fill tracker has the states FILL_EMPTY, FILL_PART and FILL_FULL. It moves FILL_EMPTY→FILL_PART on a push and FILL_PART→FILL_FULL when a push without a pop takes the count to 16. It moves FILL_FULL→FILL_PART on a pop without a push and FILL_PART→FILL_EMPTY when a pop without a push takes the count to 0. A push together with a pop keeps the state. The overrun tracker has the states OVR_IDLE and OVR_SEEN. It moves OVR_IDLE→OVR_SEEN on an overrun event. It moves OVR_SEEN→OVR_IDLE only on a clear write in a cycle that has no overrun event.

Top module: `uart_rx_stat_buf`

## Requirements
- R1: The status word puts framing error at bit 0, parity error at bit 1, break error at bit 2 and overrun at bit 3, and reads bits 31:4 as zero.
- R2: Status bits 2:0 equal the flags of the entry removed by the latest data-offset read that found the store non-empty.
- R3: A character that arrives while the store holds 16 entries and no pop happens in that cycle sets status bit 3 in the next cycle, with no data read needed.
- R4: On overrun the store is not written: the 16 entries already held read out intact and in order, and the incoming character is lost.
- R5: A bus write of any value to offset 0x004 clears all four status bits.
- R6: The status word is read-only: a write of 0x0000000F to 0x004 leaves all status bits at zero.
- R7: After reset all status bits are 0 and the store is empty.
- R8: Characters read out in arrival order, up to 16 held. A data-offset read returns the character in bits 7:0 with bits 31:8 zero on `bus_rdata` one cycle after the strobe.
- R9: The overrun bit stays set after the store is drained and is cleared only by a clear write or by reset.
- R10: When a character arrives and a pop happens in the same cycle with the store full, the character is accepted and overrun is not set.
- R11: A data-offset read of an empty store returns 0 and leaves status bits 2:0 unchanged.
- R12: If a clear write and an overrun event fall in the same cycle, the overrun bit ends up set and bits 2:0 are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe for a finished character |
| char_data | input | 8 | Received character |
| char_frm_err | input | 1 | Framing error flag of the character |
| char_par_err | input | 1 | Parity error flag of the character |
| char_brk_err | input | 1 | Break flag of the character |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |

## Verification
The hardest cases need the store exactly full and a second event in the same clock edge as the incoming character. One is a pop, where the character must be accepted. The other is a clear write, where the overrun must still win. The bench fills the store with sixteen numbered characters so that it knows the contents. At one falling edge it then drives the character strobe together with the bus strobe, so both land on the same rising edge. Afterwards it drains the whole store. This shows from the order of the characters whether the extra one was taken or dropped.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
    localparam int CHAR_W   = 8;
    localparam int ERR_W    = 3;
    localparam int STAT_W   = ERR_W + 1;

    // status word bit positions (software decodes these)
    localparam int ST_FRM   = 0;
    localparam int ST_PAR   = 1;
    localparam int ST_BRK   = 2;
    localparam int ST_OVR   = 3;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rx_err_t;

    typedef struct packed {
        rx_err_t             err;
        logic [CHAR_W-1:0]   data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_t;

    typedef enum logic {
        OVR_IDLE = 1'b0,
        OVR_SEEN = 1'b1
    } ovr_state_t;
endpackage

// File: rtl/rxs_fifo_mem.sv
module rxs_fifo_mem
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      rd_en,
    output rx_entry_t head_entry
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    rx_entry_t        store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= step(wr_ptr);
            if (rd_en) rd_ptr <= step(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= wr_entry;
    end

    assign head_entry = store[rd_ptr];
endmodule

// File: rtl/rxs_fill_fsm.sv
module rxs_fill_fsm
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic             is_empty,
    output logic             is_full,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    fill_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (push) state_d = (TOP == 1) ? FILL_FULL : FILL_PART;
            FILL_PART: begin
                if (push && !pop && count == TOP - 1'b1)      state_d = FILL_FULL;
                else if (pop && !push && count == CNT_W'(1))  state_d = FILL_EMPTY;
            end
            FILL_FULL:  if (pop && !push) state_d = (TOP == 1) ? FILL_EMPTY : FILL_PART;
            default:    state_d = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count <= '0;
        else if (push && !pop)  count <= count + 1'b1;
        else if (pop && !push)  count <= count - 1'b1;
    end

    always_comb begin
        is_empty = (state_q == FILL_EMPTY);
        is_full  = (state_q == FILL_FULL);
    end
endmodule

// File: rtl/rxs_err_status.sv
module rxs_err_status
    import uart_rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  rx_err_t           pop_err,
    input  logic              clr,
    input  logic              ovr_evt,
    output logic [STAT_W-1:0] stat_bits
);
    ovr_state_t ovr_q, ovr_d;
    rx_err_t    last_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= OVR_IDLE;
        else        ovr_q <= ovr_d;
    end

    always_comb begin
        ovr_d = ovr_q;
        unique case (ovr_q)
            OVR_IDLE: if (ovr_evt)         ovr_d = OVR_SEEN;
            OVR_SEEN: if (clr && !ovr_evt) ovr_d = OVR_IDLE;
            default:  ovr_d = OVR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   last_err <= '0;
        else if (clr) last_err <= '0;
        else if (pop) last_err <= pop_err;
    end

    always_comb begin
        stat_bits         = '0;
        stat_bits[ST_FRM] = last_err.frm;
        stat_bits[ST_PAR] = last_err.par;
        stat_bits[ST_BRK] = last_err.brk;
        stat_bits[ST_OVR] = (ovr_q == OVR_SEEN);
    end
endmodule

// File: rtl/uart_rx_stat_buf.sv
module uart_rx_stat_buf
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 12,
    parameter int BUS_W    = 32,
    parameter int DATA_OFS = 'h000,
    parameter int STAT_OFS = 'h004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_frm_err,
    input  logic              char_par_err,
    input  logic              char_brk_err,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             hit_data, hit_stat;
    logic             rd_pop, err_clr, ovr_evt, push, empty_data_rd;
    logic             fifo_empty, fifo_full;
    logic [CNT_W-1:0] fifo_count;
    logic [STAT_W-1:0] stat_bits;
    rx_entry_t        in_entry, head_entry;

    assign hit_data = bus_en && (bus_addr == ADDR_W'(DATA_OFS));
    assign hit_stat = bus_en && (bus_addr == ADDR_W'(STAT_OFS));

    assign rd_pop        = hit_data && !bus_we && !fifo_empty;
    assign empty_data_rd = hit_data && !bus_we &&  fifo_empty;
    assign err_clr       = hit_stat &&  bus_we;
    assign push          = char_valid && (!fifo_full || rd_pop);
    assign ovr_evt       = char_valid &&  fifo_full && !rd_pop;

    always_comb begin
        in_entry.data    = char_data;
        in_entry.err.frm = char_frm_err;
        in_entry.err.par = char_par_err;
        in_entry.err.brk = char_brk_err;
    end

    rxs_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_entry(in_entry),
        .rd_en(rd_pop), .head_entry(head_entry)
    );

    rxs_fill_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .push(push), .pop(rd_pop),
        .is_empty(fifo_empty), .is_full(fifo_full), .count(fifo_count)
    );

    rxs_err_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .pop(rd_pop), .pop_err(head_entry.err),
        .clr(err_clr), .ovr_evt(ovr_evt),
        .stat_bits(stat_bits)
    );

    // registered read port; written data is never stored anywhere
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_en && !bus_we) begin
            if (rd_pop)        bus_rdata <= BUS_W'(head_entry.data);
            else if (hit_stat) bus_rdata <= BUS_W'(stat_bits);
            else               bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/uart_rxs_chk.sv
module uart_rxs_chk
    import uart_rxs_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int BUS_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic              pop,
    input logic              full,
    input logic [CNT_W-1:0]  count,
    input logic [STAT_W-1:0] stat_bits,
    input logic              clr,
    input logic              empty_rd,
    input logic [BUS_W-1:0]  bus_rdata
);
    p_ovr_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && full && !pop |=> stat_bits[ST_OVR]);

    p_fifo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && full && !pop |=> $stable(count) && full);

    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !(char_valid && full) |=> stat_bits == '0);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_bits[ST_OVR] && !clr |=> stat_bits[ST_OVR]);

    p_accept_on_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid && full && pop && !stat_bits[ST_OVR] |=> !stat_bits[ST_OVR] && full);

    p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd && !clr |=> bus_rdata == '0 && $stable(stat_bits[ST_BRK:ST_FRM]));

    p_clear_vs_ovr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr && char_valid && full |=> stat_bits == STAT_W'(1 << ST_OVR));
endmodule

bind uart_rx_stat_buf uart_rxs_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .pop(rd_pop),
    .full(fifo_full), .count(fifo_count), .stat_bits(stat_bits),
    .clr(err_clr), .empty_rd(empty_data_rd), .bus_rdata(bus_rdata)
);

// File: tb/tb_uart_rx_stat_buf.sv
`timescale 1ns/1ps
module tb_uart_rx_stat_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = '0;
    logic        char_frm_err = 1'b0, char_par_err = 1'b0, char_brk_err = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    uart_rx_stat_buf dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_char(input logic [7:0] d, input logic [2:0] f);
        @(negedge clk);
        char_valid = 1'b1; char_data = d;
        {char_brk_err, char_par_err, char_frm_err} = f;
        @(negedge clk);
        char_valid = 1'b0; {char_brk_err, char_par_err, char_frm_err} = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic fill16();
        for (int i = 1; i <= 16; i++) push_char(8'(i), 3'b000);
    endtask

    task automatic t_reset();
        bus_read(12'h004, rv); check("R7 status after reset", rv, 32'h0);
        bus_read(12'h000, rv); check("R11 empty read after reset", rv, 32'h0);
    endtask

    task automatic t_order_and_flags();
        push_char(8'hA1, 3'b001);
        push_char(8'hB2, 3'b010);
        push_char(8'hC3, 3'b100);
        push_char(8'hD4, 3'b111);
        bus_read(12'h000, rv); check("R8 first char", rv, 32'hA1);
        bus_read(12'h004, rv); check("R1 R2 framing at bit0", rv, 32'h1);
        bus_read(12'h000, rv); check("R8 second char", rv, 32'hB2);
        bus_read(12'h004, rv); check("R1 R2 parity at bit1", rv, 32'h2);
        bus_read(12'h000, rv); check("R8 third char", rv, 32'hC3);
        bus_read(12'h004, rv); check("R1 R2 break at bit2", rv, 32'h4);
        bus_read(12'h000, rv); check("R8 fourth char", rv, 32'hD4);
        bus_read(12'h004, rv); check("R2 all flags", rv, 32'h7);
        bus_read(12'h000, rv); check("R11 empty read data", rv, 32'h0);
        bus_read(12'h004, rv); check("R11 flags kept after empty read", rv, 32'h7);
    endtask

    task automatic t_clear();
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_read(12'h004, rv); check("R5 clear with all ones", rv, 32'h0);
        bus_write(12'h004, 32'h0000_000F);
        bus_read(12'h004, rv); check("R6 write does not load", rv, 32'h0);
    endtask

    task automatic t_overrun();
        fill16();
        push_char(8'hEE, 3'b111);
        bus_read(12'h004, rv); check("R3 overrun set before any data read", rv, 32'h8);
        for (int i = 1; i <= 16; i++) begin
            bus_read(12'h000, rv); check("R4 held entry intact", rv, 32'(i));
        end
        bus_read(12'h000, rv); check("R4 overrun char lost", rv, 32'h0);
        bus_read(12'h004, rv); check("R9 overrun sticky after drain", rv, 32'h8);
        bus_write(12'h004, 32'h0);
        bus_read(12'h004, rv); check("R9 overrun cleared by write", rv, 32'h0);
    endtask

    task automatic t_push_pop_full();
        fill16();
        @(negedge clk);
        char_valid = 1'b1; char_data = 8'h77;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        @(negedge clk);
        char_valid = 1'b0; bus_en = 1'b0;
        check("R10 popped oldest", bus_rdata, 32'h1);
        bus_read(12'h004, rv); check("R10 no overrun", rv, 32'h0);
        for (int i = 2; i <= 16; i++) begin
            bus_read(12'h000, rv); check("R10 remaining order", rv, 32'(i));
        end
        bus_read(12'h000, rv); check("R10 new char accepted", rv, 32'h77);
    endtask

    task automatic t_clear_vs_overrun();
        push_char(8'h55, 3'b110);
        bus_read(12'h000, rv); check("R8 single char", rv, 32'h55);
        fill16();
        @(negedge clk);
        char_valid = 1'b1; char_data = 8'h99;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h0;
        @(negedge clk);
        char_valid = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        bus_read(12'h004, rv); check("R12 overrun wins over clear", rv, 32'h8);
        for (int i = 1; i <= 16; i++) begin
            bus_read(12'h000, rv); check("R12 store unchanged", rv, 32'(i));
        end
        bus_write(12'h004, 32'h1234);
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order_and_flags();
        t_clear();
        t_overrun();
        t_push_pop_full();
        t_clear_vs_overrun();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule